// File: doc/BRIEF.md
# Serial Bus Controller Interrupt Status Unit

This unit collects twelve interrupt sources of a serial bus controller into one register bank and one level interrupt line. Ten sources are short event pulses from the bus engine. Each pulse sets a sticky bit in the raw status, and that bit stays set until software clears it. The other two sources are level conditions. The receive-full bit is set while the receive FIFO level is above a programmable receive threshold. The transmit-empty bit is set while the transmit FIFO level is at or below a programmable transmit threshold. A mask register selects which raw bits reach the masked status, and the interrupt line is high while any masked bit is set.

Software clears a sticky source by reading a clear address. Each sticky source has its own clear address, and one combined clear address clears all sticky sources at once. Each abort event also merges a cause vector into an abort cause register. That register keeps its value until the abort source is cleared, either by its own clear read or by the combined clear read. Register access is a simple single-cycle port. Read data is combinational from the current state, and the side effects of a read take effect at the next clock edge.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the sticky status bits, the mask, both thresholds and the abort cause register are zero, and `irqOut` is low.
- R2: A pulse on `srcEvent[k]` sets raw bit k at the next clock edge for each sticky source (bits 0,1,3,5,6,7,8,9,10,11). The bit then holds until it is cleared. The bit order is: 0 rx-underflow, 1 rx-overflow, 2 rx-full, 3 tx-overflow, 4 tx-empty, 5 read-request, 6 abort, 7 rx-done, 8 activity, 9 stop, 10 start, 11 general-call.
- R3: A read at 0x2C returns the raw status ANDed with the mask in bits 11:0. `irqOut` is the OR of those masked bits.
- R4: A read at a source's clear address clears only that source's bit. The clear addresses start at 0x44 and step by 4 through the sticky sources in ascending bit order: 0x44, 0x48, 0x4C, 0x50, 0x54, 0x58, 0x5C, 0x60, 0x64, 0x68 for bits 0,1,3,5,6,7,8,9,10,11.
- R5: A read at any clear address returns zeros in bits 31:1. Bit 0 holds the value the addressed bit had before the clear; at 0x40 it holds the OR of all sticky bits.
- R6: A read at 0x40 clears all ten sticky sources in one cycle.
- R7: When an event arrives in the same cycle as a clear of its bit, the event wins and the bit stays set.
- R8: Bit 2 equals (rxLevel > receive threshold) and bit 4 equals (txLevel <= transmit threshold). These two bits follow the levels directly and are not changed by any clear read.
- R9: An abort event ORs `abortCause` into the abort cause register, readable at 0x80. The register holds its value across all other accesses until the abort source is cleared.
- R10: The mask at 0x30 (12 bits), the receive threshold at 0x38 and the transmit threshold at 0x3C can be written and read back. Writes to 0x34 have no effect, and reads of unmapped addresses return zero.
- R11: A clear read at 0x54 or 0x40 resets the abort cause register to zero. If an abort event arrives in the same cycle, the register takes that cycle's cause vector instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register byte address |
| regRd | input | 1 | Read strobe, one cycle per access |
| regWr | input | 1 | Write strobe, one cycle per access |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, valid in the cycle `regRd` is high |
| srcEvent | input | 12 | Event pulses from the bus engine; bits 2 and 4 are unused |
| abortCause | input | ABORT_W | Abort cause bits, sampled with `srcEvent[6]` |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| txLevel | input | LVL_W | Transmit FIFO fill level |
| irqOut | output | 1 | Level interrupt request |

## Verification
The assertions check on every cycle that events set their sticky bits and that sticky bits hold when no read occurs. They also check that each clear address clears its own bit and the combined address clears all sticky bits. In addition, they check that clear reads return only bit 0, that the abort cause stays stable outside a clear or an abort, and that `irqOut` tracks the masked status. The bench scenarios show the things a single property cannot. These are the full address map of the clear registers and that the level bits survive clear reads while following the threshold registers. The scenarios also cover the event-over-clear priority for both the status and the abort cause, and a reset in the middle of a run.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  localparam int SRC_N = 12;

  localparam int BIT_RX_FULL  = 2;
  localparam int BIT_TX_EMPTY = 4;
  localparam int BIT_ABORT    = 6;

  localparam logic [SRC_N-1:0] LEVEL_MASK = (SRC_N'(1) << BIT_RX_FULL) | (SRC_N'(1) << BIT_TX_EMPTY);
  localparam logic [SRC_N-1:0] STICKY_MASK = ~LEVEL_MASK;

  localparam int OFF_MASKED    = 'h2C;
  localparam int OFF_MASK      = 'h30;
  localparam int OFF_RAW       = 'h34;
  localparam int OFF_RX_TH     = 'h38;
  localparam int OFF_TX_TH     = 'h3C;
  localparam int OFF_CLR_ALL   = 'h40;
  localparam int OFF_CLR_FIRST = 'h44;
  localparam int OFF_ABORT     = 'h80;

  // Position of a sticky source among the per-source clear addresses.
  function automatic int clrSlot(int k);
    int s;
    s = 0;
    for (int i = 0; i < k; i++) begin
      if (STICKY_MASK[i]) s++;
    end
    return s;
  endfunction

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MASKED,
    RD_MASK,
    RD_RAW,
    RD_RXTH,
    RD_TXTH,
    RD_CLR,
    RD_ABORT
  } rdSel_e;

  typedef struct packed {
    logic [SRC_N-1:0] clrVec;
    logic             wrMask;
    logic             wrRxTh;
    logic             wrTxTh;
    rdSel_e           rdSel;
  } strobe_t;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_status_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  output strobe_t           strb
);

  logic [SRC_N-1:0] clrHit;
  logic             clrAllHit;

  for (genvar k = 0; k < SRC_N; k++) begin : g_clr
    if (STICKY_MASK[k]) begin : g_sticky
      assign clrHit[k] = regRd && (regAddr == ADDR_W'(OFF_CLR_FIRST + 4 * clrSlot(k)));
    end else begin : g_level
      assign clrHit[k] = 1'b0;
    end
  end

  assign clrAllHit = regRd && (regAddr == ADDR_W'(OFF_CLR_ALL));

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_NONE;
    strb.clrVec = clrAllHit ? STICKY_MASK : clrHit;
    strb.wrMask = regWr && (regAddr == ADDR_W'(OFF_MASK));
    strb.wrRxTh = regWr && (regAddr == ADDR_W'(OFF_RX_TH));
    strb.wrTxTh = regWr && (regAddr == ADDR_W'(OFF_TX_TH));
    if (regRd) begin
      if (clrAllHit || (clrHit != '0))                   strb.rdSel = RD_CLR;
      else if (regAddr == ADDR_W'(OFF_MASKED))            strb.rdSel = RD_MASKED;
      else if (regAddr == ADDR_W'(OFF_MASK))              strb.rdSel = RD_MASK;
      else if (regAddr == ADDR_W'(OFF_RAW))               strb.rdSel = RD_RAW;
      else if (regAddr == ADDR_W'(OFF_RX_TH))             strb.rdSel = RD_RXTH;
      else if (regAddr == ADDR_W'(OFF_TX_TH))             strb.rdSel = RD_TXTH;
      else if (regAddr == ADDR_W'(OFF_ABORT))             strb.rdSel = RD_ABORT;
    end
  end

endmodule

// File: rtl/irq_status_core.sv
module irq_status_core
  import irq_status_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LVL_W   = 4,
  parameter int ABORT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [SRC_N-1:0]   srcEvent,
  input  logic [ABORT_W-1:0] abortIn,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   txLevel,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);

  logic [SRC_N-1:0]   stickySts;
  logic [SRC_N-1:0]   rawSts;
  logic [SRC_N-1:0]   maskReg;
  logic [SRC_N-1:0]   maskedSts;
  logic [LVL_W-1:0]   rxTh;
  logic [LVL_W-1:0]   txTh;
  logic [ABORT_W-1:0] abortReg;
  logic               abortEv;
  logic               abortClr;
  logic               unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:SRC_N];

  // Sticky sources: a new event outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN) stickySts <= '0;
    else       stickySts <= ((stickySts & ~strb.clrVec) | srcEvent) & STICKY_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      rxTh    <= '0;
      txTh    <= '0;
    end else begin
      if (strb.wrMask) maskReg <= regWdata[SRC_N-1:0];
      if (strb.wrRxTh) rxTh    <= regWdata[LVL_W-1:0];
      if (strb.wrTxTh) txTh    <= regWdata[LVL_W-1:0];
    end
  end

  assign abortEv  = srcEvent[BIT_ABORT];
  assign abortClr = strb.clrVec[BIT_ABORT];

  always_ff @(posedge clk) begin
    if (!rstN)                    abortReg <= '0;
    else if (abortClr && abortEv) abortReg <= abortIn;
    else if (abortClr)            abortReg <= '0;
    else if (abortEv)             abortReg <= abortReg | abortIn;
  end

  always_comb begin
    rawSts               = stickySts;
    rawSts[BIT_RX_FULL]  = rxLevel > rxTh;
    rawSts[BIT_TX_EMPTY] = txLevel <= txTh;
  end

  assign maskedSts = rawSts & maskReg;
  assign irq       = |maskedSts;

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      RD_MASKED: rdData[SRC_N-1:0]   = maskedSts;
      RD_MASK:   rdData[SRC_N-1:0]   = maskReg;
      RD_RAW:    rdData[SRC_N-1:0]   = rawSts;
      RD_RXTH:   rdData[LVL_W-1:0]   = rxTh;
      RD_TXTH:   rdData[LVL_W-1:0]   = txTh;
      RD_CLR:    rdData[0]           = |(stickySts & strb.clrVec);
      RD_ABORT:  rdData[ABORT_W-1:0] = abortReg;
      default:   rdData              = '0;
    endcase
  end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int LVL_W   = 4,
  parameter int ABORT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regRd,
  input  logic               regWr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [SRC_N-1:0]   srcEvent,
  input  logic [ABORT_W-1:0] abortCause,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   txLevel,
  output logic               irqOut
);

  strobe_t strb;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .regAddr (regAddr),
    .regRd   (regRd),
    .regWr   (regWr),
    .strb    (strb)
  );

  irq_status_core #(
    .DATA_W  (DATA_W),
    .LVL_W   (LVL_W),
    .ABORT_W (ABORT_W)
  ) u_core (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regWdata (regWdata),
    .srcEvent (srcEvent),
    .abortIn  (abortCause),
    .rxLevel  (rxLevel),
    .txLevel  (txLevel),
    .rdData   (regRdata),
    .irq      (irqOut)
  );

endmodule

// File: rtl/irq_status_checks.sv
module irq_status_checks
  import irq_status_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ABORT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regRd,
  input logic [DATA_W-1:0]  regRdata,
  input logic [SRC_N-1:0]   srcEvent,
  input logic               irqOut,
  input logic [SRC_N-1:0]   rawSts,
  input logic [SRC_N-1:0]   maskReg,
  input logic [ABORT_W-1:0] abortReg
);

  logic clrAllRd;
  logic clrAbortRd;
  logic clrRangeRd;

  assign clrAllRd   = regRd && (regAddr == ADDR_W'(OFF_CLR_ALL));
  assign clrAbortRd = regRd && (regAddr == ADDR_W'(OFF_CLR_FIRST + 4 * clrSlot(BIT_ABORT)));
  assign clrRangeRd = regRd && (regAddr >= ADDR_W'(OFF_CLR_ALL))
                      && (regAddr <= ADDR_W'(OFF_CLR_FIRST + 4 * clrSlot(SRC_N - 1)))
                      && (regAddr[1:0] == 2'b00);

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((srcEvent & STICKY_MASK) != '0) |=>
      ((rawSts & $past(srcEvent & STICKY_MASK)) == $past(srcEvent & STICKY_MASK)));

  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> ((rawSts & $past(rawSts) & STICKY_MASK) == ($past(rawSts) & STICKY_MASK)));

  p_irq_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == ((rawSts & maskReg) != '0));

  for (genvar k = 0; k < SRC_N; k++) begin : g_clr_chk
    if (STICKY_MASK[k]) begin : g_sticky
      p_own_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
        (regRd && (regAddr == ADDR_W'(OFF_CLR_FIRST + 4 * clrSlot(k))) && !srcEvent[k]) |=> !rawSts[k]);
    end
  end

  p_clear_shape_r5: assert property (@(posedge clk) disable iff (!rstN)
    clrRangeRd |-> (regRdata[DATA_W-1:1] == '0));

  p_all_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrAllRd && (srcEvent == '0)) |=> ((rawSts & STICKY_MASK) == '0));

  p_abort_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!clrAllRd && !clrAbortRd && !srcEvent[BIT_ABORT]) |=> $stable(abortReg));

  p_abort_wipe_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((clrAllRd || clrAbortRd) && !srcEvent[BIT_ABORT]) |=> (abortReg == '0));

endmodule

bind irq_status_unit irq_status_checks #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .ABORT_W (ABORT_W)
) u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regRd    (regRd),
  .regRdata (regRdata),
  .srcEvent (srcEvent),
  .irqOut   (irqOut),
  .rawSts   (u_core.rawSts),
  .maskReg  (u_core.maskReg),
  .abortReg (u_core.abortReg)
);

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regRd = 1'b0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [11:0] srcEvent = '0;
  logic [15:0] abortCause = '0;
  logic [3:0]  rxLevel = '0;
  logic [3:0]  txLevel = '0;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  irq_status_unit u0 (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regRd      (regRd),
    .regWr      (regWr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .srcEvent   (srcEvent),
    .abortCause (abortCause),
    .rxLevel    (rxLevel),
    .txLevel    (txLevel),
    .irqOut     (irqOut)
  );

  typedef struct packed {
    logic [11:0] ev;
    logic        rd;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 34;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{12'h000, 1'b1, 1'b0, 8'h34, 32'h0,   32'h0,   8'd1},  // R1 raw
    '{12'h000, 1'b1, 1'b0, 8'h30, 32'h0,   32'h0,   8'd1},  // R1 mask
    '{12'h000, 1'b1, 1'b0, 8'h2C, 32'h0,   32'h0,   8'd1},  // R1 masked
    '{12'h000, 1'b1, 1'b0, 8'h80, 32'h0,   32'h0,   8'd1},  // R1 abort cause
    '{12'h000, 1'b0, 1'b1, 8'h30, 32'hFFF, 32'h0,   8'd0},
    '{12'h000, 1'b1, 1'b0, 8'h30, 32'h0,   32'hFFF, 8'd10}, // R10 mask readback
    '{12'h001, 1'b0, 1'b0, 8'h00, 32'h0,   32'h0,   8'd0},
    '{12'h000, 1'b1, 1'b0, 8'h34, 32'h0,   32'h001, 8'd2},  // R2
    '{12'h000, 1'b1, 1'b0, 8'h2C, 32'h0,   32'h001, 8'd3},  // R3
    '{12'h000, 1'b1, 1'b0, 8'h44, 32'h0,   32'h1,   8'd5},  // R5 old bit
    '{12'h000, 1'b1, 1'b0, 8'h34, 32'h0,   32'h0,   8'd4},  // R4
    '{12'h000, 1'b1, 1'b0, 8'h44, 32'h0,   32'h0,   8'd5},  // R5 now clear
    '{12'hA08, 1'b0, 1'b0, 8'h00, 32'h0,   32'h0,   8'd0},
    '{12'h000, 1'b1, 1'b0, 8'h4C, 32'h0,   32'h1,   8'd5},  // R5
    '{12'h000, 1'b1, 1'b0, 8'h34, 32'h0,   32'hA00, 8'd4},  // R4 others kept
    '{12'h002, 1'b1, 1'b0, 8'h40, 32'h0,   32'h1,   8'd6},  // R6 with event
    '{12'h000, 1'b1, 1'b0, 8'h34, 32'h0,   32'h002, 8'd7},  // R7 event wins
    '{12'h000, 1'b0, 1'b1, 8'h30, 32'h0,   32'h0,   8'd0},
    '{12'h000, 1'b1, 1'b0, 8'h2C, 32'h0,   32'h0,   8'd3},  // R3 masked off
    '{12'h000, 1'b0, 1'b1, 8'h34, 32'hFFF, 32'h0,   8'd0},
    '{12'h000, 1'b1, 1'b0, 8'h34, 32'h0,   32'h002, 8'd10}, // R10 raw read-only
    '{12'h000, 1'b1, 1'b0, 8'h40, 32'h0,   32'h1,   8'd6},  // R6
    '{12'h000, 1'b1, 1'b0, 8'h34, 32'h0,   32'h0,   8'd6},  // R6 all gone
    '{12'h000, 1'b0, 1'b1, 8'h38, 32'h3,   32'h0,   8'd0},
    '{12'h000, 1'b1, 1'b0, 8'h38, 32'h0,   32'h3,   8'd10}, // R10 rx threshold
    '{12'h000, 1'b0, 1'b1, 8'h3C, 32'h5,   32'h0,   8'd0},
    '{12'h000, 1'b1, 1'b0, 8'h3C, 32'h0,   32'h5,   8'd10}, // R10 tx threshold
    '{12'h000, 1'b1, 1'b0, 8'h34, 32'h0,   32'h010, 8'd8},  // R8 tx empty
    '{12'h000, 1'b1, 1'b0, 8'h40, 32'h0,   32'h0,   8'd8},  // R8 level not sticky
    '{12'h000, 1'b1, 1'b0, 8'h34, 32'h0,   32'h010, 8'd8},  // R8 survives clear
    '{12'h000, 1'b0, 1'b1, 8'h3C, 32'h0,   32'h0,   8'd0},
    '{12'h000, 1'b1, 1'b0, 8'h34, 32'h0,   32'h0,   8'd8},  // R8 follows threshold
    '{12'h000, 1'b1, 1'b0, 8'h90, 32'h0,   32'h0,   8'd10}, // R10 unmapped
    '{12'h000, 1'b1, 1'b0, 8'h6C, 32'h0,   32'h0,   8'd10}  // R10 unmapped
  };

  localparam logic [7:0] CLR_ADDR [0:11] = '{
    8'h44, 8'h48, 8'h00, 8'h4C, 8'h00, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h60, 8'h64, 8'h68
  };

  task automatic cyc(input logic [11:0] ev, input logic rd, input logic wr,
                     input logic [7:0] addr, input logic [31:0] wd,
                     input logic [15:0] cause, output logic [31:0] rv);
    @(negedge clk);
    srcEvent   = ev;
    regRd      = rd;
    regWr      = wr;
    regAddr    = addr;
    regWdata   = wd;
    abortCause = cause;
    #1 rv = regRdata;
    @(posedge clk);
    #1;
    srcEvent   = '0;
    regRd      = 1'b0;
    regWr      = 1'b0;
    regAddr    = '0;
    regWdata   = '0;
    abortCause = '0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rdChk(input string req, input logic [7:0] addr, input logic [31:0] exp);
    logic [31:0] rv;
    cyc(12'h000, 1'b1, 1'b0, addr, 32'h0, 16'h0, rv);
    check(req, rv, exp);
  endtask

  task automatic wrReg(input logic [7:0] addr, input logic [31:0] wd);
    logic [31:0] rv;
    cyc(12'h000, 1'b0, 1'b1, addr, wd, 16'h0, rv);
  endtask

  task automatic pulse(input logic [11:0] ev, input logic [15:0] cause);
    logic [31:0] rv;
    cyc(ev, 1'b0, 1'b0, 8'h00, 32'h0, cause, rv);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    txLevel = 4'd5;
    rxLevel = 4'd0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      cyc(VECS[i].ev, VECS[i].rd, VECS[i].wr, VECS[i].addr, VECS[i].wd, 16'h0, rv);
      if (VECS[i].rd) check($sformatf("R%0d vec%0d", VECS[i].req, i), rv, VECS[i].exp);
    end

    // R4 R5: every clear address clears its own source
    for (int k = 0; k < 12; k++) begin
      if (k != 2 && k != 4) begin
        pulse(12'(1 << k), 16'h0);
        rdChk($sformatf("R5 clr bit %0d", k), CLR_ADDR[k], 32'h1);
        rdChk($sformatf("R4 clr bit %0d", k), 8'h34, 32'h0);
      end
    end

    // R8: receive level above threshold, immune to clears
    rxLevel = 4'd4;
    rdChk("R8 rx full", 8'h34, 32'h004);
    rdChk("R3 masked off", 8'h2C, 32'h0);
    wrReg(8'h30, 32'h004);
    check("R3 irq high", {31'b0, irqOut}, 32'h1);
    rdChk("R5 clr all no sticky", 8'h40, 32'h0);
    rdChk("R8 rx full kept", 8'h34, 32'h004);
    rxLevel = 4'd3;
    rdChk("R8 rx at threshold", 8'h34, 32'h0);
    check("R3 irq low", {31'b0, irqOut}, 32'h0);

    // R9 R11: abort cause capture, hold and wipe
    wrReg(8'h30, 32'h040);
    pulse(12'h040, 16'h0009);
    rdChk("R9 cause", 8'h80, 32'h0009);
    check("R3 irq abort", {31'b0, irqOut}, 32'h1);
    pulse(12'h040, 16'h0100);
    rdChk("R9 cause merge", 8'h80, 32'h0109);
    rdChk("R4 other clear", 8'h58, 32'h0);
    rdChk("R9 cause held", 8'h80, 32'h0109);
    rdChk("R5 abort clr", 8'h54, 32'h1);
    rdChk("R11 cause wiped", 8'h80, 32'h0);
    check("R3 irq after clr", {31'b0, irqOut}, 32'h0);
    cyc(12'h040, 1'b1, 1'b0, 8'h54, 32'h0, 16'h0020, rv);
    check("R5 abort clr old", rv, 32'h0);
    rdChk("R11 new cause wins", 8'h80, 32'h0020);
    rdChk("R7 abort kept", 8'h34, 32'h040);
    rdChk("R6 clr all", 8'h40, 32'h1);
    rdChk("R11 combined wipe", 8'h80, 32'h0);

    // R1: reset in the middle of a run
    rxLevel = 4'd0;
    pulse(12'h800, 16'h0);
    wrReg(8'h30, 32'hFFF);
    wrReg(8'h38, 32'h7);
    check("R3 irq before reset", {31'b0, irqOut}, 32'h1);
    @(negedge clk) rstN = 1'b0;
    @(posedge clk);
    #1 rstN = 1'b1;
    check("R1 irq after reset", {31'b0, irqOut}, 32'h0);
    rdChk("R1 raw after reset", 8'h34, 32'h0);
    rdChk("R1 mask after reset", 8'h30, 32'h0);
    rdChk("R1 rx threshold after reset", 8'h38, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule